// File: doc/BRIEF.md
# RGB Input Prescale Stage

This block sits at the front of a pixel pipeline and multiplies each of the red, green and blue channels of a streaming pixel by its own unsigned fixed-point gain, then adds a signed offset to it. The result is clamped to the channel range. Pixels arrive as a valid/data stream, and the processed pixel leaves two clock cycles later with its valid signal delayed by the same amount.

Software programs the block through a simple write port. One control word holds a bypass bit and a bit that requests the legacy gamma table. Gains and offsets are written into shadow registers, and they move into the working set only when the frame-start strobe pulses, so a single frame is always processed with one coefficient set. The bypass bit acts at once. Software sets it before it reloads the coefficients and clears it once they are in place. The gamma table is not part of this block. The block drives a select output toward it and forwards, with the same latency, the table result that arrives on a separate input. It grants the table only while prescaling is bypassed, so an active prescale always forces the path that skips the table.

Top module: `prescale_top`

## Requirements
- R1: After reset, pix_vld_o and gamma_legacy_o are 0, bypass is set (bit 0 of the control word is 1), the legacy bit is 0, every working gain is 1.0 (0x4000) and every working offset is 0.
- R2: With bypass clear and the legacy bit clear, each output channel equals floor(in * gain / 2^14) + offset, clamped. The gain is unsigned 2.14 and the offset is signed 16-bit two's complement, taken from the working set.
- R3: The clamp bounds the result: a negative result gives 0 and a result above 2^CH_W-1 gives 2^CH_W-1.
- R4: The channels are independent. Channel 0 (red) occupies the lowest CH_W bits of pix_i and pix_o, then green, then blue. Gain registers sit at addresses 1, 2 and 3 and offset registers at addresses 4, 5 and 6 (red, green, blue). The control word is at address 0.
- R5: While bypass is set and the legacy bit is clear, pix_o equals pix_i unchanged, for any coefficient values.
- R6: pix_vld_o follows pix_vld_i exactly two clock cycles later, and pix_o belongs to the input pixel sampled two cycles earlier.
- R7: A gain or offset write has no effect on the output until sof_i is sampled high. The new set applies to pixels sampled after that edge.
- R8: gamma_legacy_o is 1 only when the last control write set both bit 0 (bypass) and bit 1 (legacy). In that state pix_o equals lut_pix_i from two cycles earlier.
- R9: A control write with bit 0 clear forces gamma_legacy_o to 0 even when bit 1 is set, and the prescaled result then appears on pix_o.
- R10: A control write takes effect for the very next pixel, without waiting for sof_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| sof_i | input | 1 | Frame-start strobe that loads the shadow coefficients |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_i | input | 3*CH_W | Input pixel, red in the low bits |
| lut_pix_i | input | 3*CH_W | Legacy table result aligned with pix_i |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_o | output | 3*CH_W | Output pixel |
| gamma_legacy_o | output | 1 | 1 selects the legacy gamma table, 0 skips it |

## Verification
Each channel gets a different input ramp so that the channels cannot stand in for one another. All 256 input codes are swept against several coefficient sets. Unity gain with zero offset shows whether the fixed-point alignment is right. A half gain with a positive offset and a near-4.0 gain with a negative offset exercise truncation and both clamp edges. A zero gain with a large offset, and a large negative offset, pin the outputs at the two rails. A bypass sweep with extreme coefficients separates true pass-through from unity scaling. Coefficient writes made without a frame strobe, followed by a strobe, show the shadow/working split, and the control-word combinations show how the legacy gate resolves.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int NCH        = 3;
  localparam int REG_ADDR_W = 3;
  localparam int REG_DATA_W = 16;
  localparam int FRAC_BITS  = 14;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_GAIN0  = 1;
  localparam int ADR_OFFS0  = 4;
  localparam int CTRL_BYP   = 0;
  localparam int CTRL_LEG   = 1;
endpackage

// File: rtl/prescale_regs.sv
module prescale_regs
  import prescale_pkg::*;
#(
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [REG_ADDR_W-1:0]       addr,
  input  logic [REG_DATA_W-1:0]       wdata,
  input  logic                        sof,
  output logic                        byp_o,
  output logic                        leg_o,
  output logic                        gsel_o,
  output logic [NCH*SCALE_W-1:0]      gain_o,
  output logic [NCH*BIAS_W-1:0]       offs_o
);
  localparam logic [SCALE_W-1:0] GAIN_ONE = SCALE_W'(1 << FRAC_BITS);
  localparam logic [REG_ADDR_W-1:0] A_CTRL = REG_ADDR_W'(ADR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_o  <= 1'b1;
      leg_o  <= 1'b0;
      gsel_o <= 1'b0;
    end else if (we && addr == A_CTRL) begin
      byp_o  <= wdata[CTRL_BYP];
      leg_o  <= wdata[CTRL_LEG];
      gsel_o <= wdata[CTRL_BYP] & wdata[CTRL_LEG];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [REG_ADDR_W-1:0] A_GAIN = REG_ADDR_W'(ADR_GAIN0 + c);
    localparam logic [REG_ADDR_W-1:0] A_OFFS = REG_ADDR_W'(ADR_OFFS0 + c);
    logic [SCALE_W-1:0] gain_sh, gain_act;
    logic [BIAS_W-1:0]  offs_sh, offs_act;

    always_ff @(posedge clk) begin
      if (rst) begin
        gain_sh  <= GAIN_ONE;
        offs_sh  <= '0;
        gain_act <= GAIN_ONE;
        offs_act <= '0;
      end else begin
        if (we && addr == A_GAIN) gain_sh <= wdata[SCALE_W-1:0];
        if (we && addr == A_OFFS) offs_sh <= wdata[BIAS_W-1:0];
        if (sof) begin
          gain_act <= gain_sh;
          offs_act <= offs_sh;
        end
      end
    end

    assign gain_o[c*SCALE_W +: SCALE_W] = gain_act;
    assign offs_o[c*BIAS_W +: BIAS_W]   = offs_act;
  end
endmodule

// File: rtl/prescale_chan.sv
module prescale_chan
  import prescale_pkg::*;
#(
  parameter int CH_W    = 10,
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CH_W-1:0]    pix_in,
  input  logic [CH_W-1:0]    lut_in,
  input  logic [SCALE_W-1:0] gain,
  input  logic [BIAS_W-1:0]  offs,
  input  logic               byp_s1,
  input  logic               leg_s1,
  output logic [CH_W-1:0]    pix_out
);
  localparam int PROD_W = CH_W + SCALE_W;
  localparam int PS_W   = PROD_W - FRAC_BITS;
  localparam int SUM_W  = ((PS_W + 1) > BIAS_W ? (PS_W + 1) : BIAS_W) + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << CH_W) - 1);

  logic [PS_W-1:0]   prod_q;
  logic [BIAS_W-1:0] offs_q;
  logic [CH_W-1:0]   in_q, lut_q;

  // stage 1: multiply and align to the integer grid
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      offs_q <= '0;
      in_q   <= '0;
      lut_q  <= '0;
    end else begin
      prod_q <= PS_W'(({{SCALE_W{1'b0}}, pix_in} * {{CH_W{1'b0}}, gain}) >> FRAC_BITS);
      offs_q <= offs;
      in_q   <= pix_in;
      lut_q  <= lut_in;
    end
  end

  // stage 2: offset, clamp, path select
  logic signed [SUM_W-1:0] a_s, b_s, sum_s;
  logic [CH_W-1:0] clamped;
  always_comb begin
    a_s   = {{(SUM_W-PS_W){1'b0}}, prod_q};
    b_s   = {{(SUM_W-BIAS_W){offs_q[BIAS_W-1]}}, offs_q};
    sum_s = a_s + b_s;
    if (sum_s < 0)         clamped = '0;
    else if (sum_s > MAXV) clamped = '1;
    else                   clamped = sum_s[CH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          pix_out <= '0;
    else if (leg_s1)  pix_out <= lut_q;
    else if (byp_s1)  pix_out <= in_q;
    else              pix_out <= clamped;
  end
endmodule

// File: rtl/prescale_top.sv
module prescale_top
  import prescale_pkg::*;
#(
  parameter int CH_W    = 10,
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  input  logic                  sof_i,
  input  logic                  pix_vld_i,
  input  logic [NCH*CH_W-1:0]   pix_i,
  input  logic [NCH*CH_W-1:0]   lut_pix_i,
  output logic                  pix_vld_o,
  output logic [NCH*CH_W-1:0]   pix_o,
  output logic                  gamma_legacy_o
);
  logic ctrl_byp, ctrl_leg;
  logic [NCH*SCALE_W-1:0] act_gain;
  logic [NCH*BIAS_W-1:0]  act_offs;
  logic vld_s1, byp_s1, leg_s1;

  prescale_regs #(.SCALE_W(SCALE_W), .BIAS_W(BIAS_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sof(sof_i), .byp_o(ctrl_byp), .leg_o(ctrl_leg), .gsel_o(gamma_legacy_o),
    .gain_o(act_gain), .offs_o(act_offs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1    <= 1'b0;
      byp_s1    <= 1'b1;
      leg_s1    <= 1'b0;
      pix_vld_o <= 1'b0;
    end else begin
      vld_s1    <= pix_vld_i;
      byp_s1    <= ctrl_byp;
      leg_s1    <= ctrl_byp & ctrl_leg;
      pix_vld_o <= vld_s1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    prescale_chan #(.CH_W(CH_W), .SCALE_W(SCALE_W), .BIAS_W(BIAS_W)) chan_i (
      .clk(clk), .rst(rst),
      .pix_in(pix_i[c*CH_W +: CH_W]),
      .lut_in(lut_pix_i[c*CH_W +: CH_W]),
      .gain(act_gain[c*SCALE_W +: SCALE_W]),
      .offs(act_offs[c*BIAS_W +: BIAS_W]),
      .byp_s1(byp_s1), .leg_s1(leg_s1),
      .pix_out(pix_o[c*CH_W +: CH_W])
    );
  end
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk
  import prescale_pkg::*;
#(
  parameter int CH_W    = 10,
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sof_i,
  input logic                     pix_vld_i,
  input logic [NCH*CH_W-1:0]      pix_i,
  input logic                     pix_vld_o,
  input logic [NCH*CH_W-1:0]      pix_o,
  input logic                     gamma_legacy_o,
  input logic                     ctrl_byp,
  input logic                     ctrl_leg,
  input logic [NCH*SCALE_W-1:0]   act_gain,
  input logic [NCH*BIAS_W-1:0]    act_offs
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (pix_vld_o == $past(pix_vld_i, 2))); // R6

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && pix_vld_o && $past(ctrl_byp, 2) && !$past(ctrl_leg, 2))
      |-> (pix_o == $past(pix_i, 2))); // R5

  AST_LEGACY_NEEDS_BYPASS: assert property (@(posedge clk) disable iff (rst)
    gamma_legacy_o |-> ctrl_byp); // R8

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sof_i |=> ($stable(act_gain) && $stable(act_offs))); // R7
endmodule

bind prescale_top prescale_chk #(.CH_W(CH_W), .SCALE_W(SCALE_W), .BIAS_W(BIAS_W)) chk_i (
  .clk(clk), .rst(rst), .sof_i(sof_i), .pix_vld_i(pix_vld_i), .pix_i(pix_i),
  .pix_vld_o(pix_vld_o), .pix_o(pix_o), .gamma_legacy_o(gamma_legacy_o),
  .ctrl_byp(ctrl_byp), .ctrl_leg(ctrl_leg), .act_gain(act_gain), .act_offs(act_offs)
);

// File: tb/prescale_top_tb.sv
`timescale 1ns/1ps
module prescale_top_tb_top;
  localparam int CW = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic sof_i = 1'b0;
  logic pix_vld_i = 1'b0;
  logic [3*CW-1:0] pix_i = '0;
  logic [3*CW-1:0] lut_pix_i = '0;
  logic pix_vld_o;
  logic [3*CW-1:0] pix_o;
  logic gamma_legacy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prescale_top #(.CH_W(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sof_i(sof_i), .pix_vld_i(pix_vld_i), .pix_i(pix_i), .lut_pix_i(lut_pix_i),
    .pix_vld_o(pix_vld_o), .pix_o(pix_o), .gamma_legacy_o(gamma_legacy_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(int x, int g, int b);
    int v;
    v = ((x * g) >>> 14) + b;
    if (v < 0) v = 0;
    if (v > MAXV) v = MAXV;
    return v;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic frame_start();
    @(negedge clk);
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
  endtask

  task automatic set_coefs(int g0, int g1, int g2, int b0, int b1, int b2);
    wr(1, g0); wr(2, g1); wr(3, g2);
    wr(4, b0); wr(5, b1); wr(6, b2);
  endtask

  // drive one pixel; returns output sampled two edges later
  task automatic send(input int r, input int g, input int b, input int lr, input int lg,
                      input int lb, output int o0, output int o1, output int o2, output int ov);
    @(negedge clk);
    pix_vld_i = 1'b1;
    pix_i = {8'(b), 8'(g), 8'(r)};
    lut_pix_i = {8'(lb), 8'(lg), 8'(lr)};
    @(negedge clk);
    pix_vld_i = 1'b0;
    @(negedge clk);
    o0 = int'(pix_o[7:0]); o1 = int'(pix_o[15:8]); o2 = int'(pix_o[23:16]);
    ov = int'(pix_vld_o);
  endtask

  task automatic sweep(string req, int g0, int g1, int g2, int b0, int b1, int b2, bit byp);
    int o0, o1, o2, ov;
    for (int i = 0; i < 256; i++) begin
      int r = i, g = 255 - i, b = (i * 37) & 255;
      send(r, g, b, 0, 0, 0, o0, o1, o2, ov);
      check(req, ov, 1);
      check(req, o0, byp ? r : expv(r, g0, b0));
      check(req, o1, byp ? g : expv(g, g1, b1));
      check(req, o2, byp ? b : expv(b, g2, b2));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int o0, o1, o2, ov;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 vld", int'(pix_vld_o), 0);
    check("R1 gsel", int'(gamma_legacy_o), 0);
    send(10, 20, 30, 0, 0, 0, o0, o1, o2, ov);
    check("R1 bypass default", o0, 10);
    wr(0, 0);
    send(200, 7, 99, 0, 0, 0, o0, o1, o2, ov);
    check("R1 unity gain r", o0, 200);
    check("R1 unity gain g", o1, 7);
    check("R1 unity gain b", o2, 99);

    // R6 latency: one edge after drive valid is still low
    @(negedge clk);
    pix_vld_i = 1'b1; pix_i = {8'd3, 8'd2, 8'd1};
    @(negedge clk);
    pix_vld_i = 1'b0;
    check("R6 not yet valid", int'(pix_vld_o), 0);
    @(negedge clk);
    check("R6 valid at two", int'(pix_vld_o), 1);
    check("R6 data", int'(pix_o[7:0]), 1);
    @(negedge clk);
    check("R6 valid drops", int'(pix_vld_o), 0);

    // R2 R4 R3: distinct per-channel sets
    set_coefs(16'h4000, 16'h2000, 16'hFFFF, 0, 10, 16'hFF9C);
    frame_start();
    sweep("R2 R4 set A", 16'h4000, 16'h2000, 16'hFFFF, 0, 10, -100, 1'b0);
    set_coefs(0, 16'h4000, 16'h5555, 300, 16'hFED4, 7);
    frame_start();
    sweep("R3 clamp set B", 0, 16'h4000, 16'h5555, 300, -300, 7, 1'b0);

    // R7: writes without frame strobe leave set B in force
    set_coefs(16'h4000, 16'h4000, 16'h4000, 0, 0, 0);
    send(100, 100, 100, 0, 0, 0, o0, o1, o2, ov);
    check("R7 old set r", o0, expv(100, 0, 300));
    check("R7 old set g", o1, 0);
    check("R7 old set b", o2, expv(100, 16'h5555, 7));
    frame_start();
    send(100, 50, 25, 0, 0, 0, o0, o1, o2, ov);
    check("R7 new set r", o0, 100);
    check("R7 new set g", o1, 50);
    check("R7 new set b", o2, 25);

    // R10 R5: bypass acts at once, pass-through with extreme coefficients
    set_coefs(16'hFFFF, 0, 16'h0001, 16'h7FFF, 16'h8000, 16'hFF00);
    frame_start();
    wr(0, 1);
    send(123, 45, 6, 0, 0, 0, o0, o1, o2, ov);
    check("R10 immediate bypass", o0, 123);
    sweep("R5 bypass sweep", 0, 0, 0, 0, 0, 0, 1'b1);

    // R8 legacy path
    wr(0, 3);
    check("R8 gsel set", int'(gamma_legacy_o), 1);
    send(1, 2, 3, 77, 88, 99, o0, o1, o2, ov);
    check("R8 lut r", o0, 77);
    check("R8 lut g", o1, 88);
    check("R8 lut b", o2, 99);

    // R9 legacy request without bypass is refused
    wr(0, 2);
    check("R9 gsel forced low", int'(gamma_legacy_o), 0);
    send(10, 20, 30, 77, 88, 99, o0, o1, o2, ov);
    check("R9 prescaled r", o0, expv(10, 16'hFFFF, 32767));
    check("R9 prescaled g", o1, 0);
    check("R9 prescaled b", o2, 0);
    wr(0, 1);
    check("R9 bypass only", int'(gamma_legacy_o), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule